// File: doc/BRIEF.md
# Multi-cycle 8-bit processor core

A small sequential processor that runs one 16-bit instruction at a time out of a byte-wide external memory. It holds four 8-bit general registers, a hidden staging register, a 12-bit program counter, a separate memory address register that always drives the address bus, and a 16-bit instruction register. Sixteen operations are decoded from the top four instruction bits: immediate load, register copy, add with signed overflow, four bitwise operations, one-place arithmetic shifts, exchange, unconditional and zero-conditional jumps, memory read, memory write, a no-operation and a halt.

Each instruction is fetched as two bytes at consecutive addresses, high byte first. Execution then takes one to three further cycles. Two-operand operations first copy the source register into the staging register, then write the destination back in the next cycle. An exchange takes three transfers through the staging register. The memory is outside the block. It samples the address on a rising edge and returns read data during the following cycle. A write happens on the edge that ends a cycle with the write strobe high. The bus has fixed timing. There is no valid/ready handshake and no back-pressure, so the memory must keep up every cycle.

Top module: `cpu8_core`

## Requirements
- R1: While reset is low, the address bus, write strobe, write data and overflow output are all zero. After reset is released, the first byte fetched comes from address 0 and all four registers read as zero.
- R2: An instruction is made of a high byte at address p and a low byte at p+1. Its fields are: opcode in bits 15:12, destination register Rx in bits 11:10, source register Ry in bits 9:8, immediate in bits 11:8, and direct address in bits 11:0. The core presents p, then p+1, then p+2 twice. Single-step operations then go straight to the next fetch. Add, the bitwise operations and write take one extra cycle. Exchange and read take two extra cycles.
- R3: Opcode 0001 loads the zero-extended 4-bit immediate into R0.
- R4: Opcode 0010 copies Ry into Rx.
- R5: Opcodes 0100, 0101, 0110 and 0111 set Rx to Rx AND Ry, NAND, OR and XNOR with Ry respectively.
- R6: Opcode 0011 sets Rx to (Rx + Ry) mod 256. The overflow output then shows 1 if the signed sum lies outside -128..127, and 0 otherwise. It changes only at the end of an add and holds its value between adds.
- R7: Opcode 1000 sets Rx to Ry shifted right by one with the sign bit copied. Opcode 1001 sets Rx to Ry shifted left by one with a zero filled in.
- R8: Opcode 1010 exchanges Rx and Ry. When Rx equals Ry, both are left unchanged.
- R9: Opcode 1011 makes the next fetch come from bits 11:0. Opcode 1100 does the same only when R0 is zero; otherwise execution continues at p+2.
- R10: Opcode 1101 presents bits 11:0 as a read address for one cycle and loads the returned byte into R0. Fetching then resumes at p+2.
- R11: Opcode 1110 raises the write strobe for exactly one cycle, with bits 11:0 on the address bus and R0 on the write data bus. The write data bus is zero in every other cycle.
- R12: Opcode 0000 changes nothing but the program counter. Opcode 1111 halts the core: the address stays frozen and the strobe stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_we | output | 1 | 1 = write this cycle, 0 = read |
| mem_wdata | output | 8 | Write data (R0 while writing, else zero) |
| mem_rdata | input | 8 | Read data for the address of the previous cycle |
| overflow | output | 1 | Signed overflow of the most recent add |

## Verification
Several cycles carry two actions at once. In the execute cycle of a read, the data address goes out on the bus while the address register is already reloaded with the program counter. In the final read cycle, the returned byte lands in R0 during the same cycle that sets up the next fetch. The program exercises these cases directly: a read of a location the program has just written, a write followed at once by a fetch, and an add whose overflow bit changes in the same cycle the following instruction's first byte is requested. A behavioural instruction-level model predicts the address, strobe, write data and overflow for every cycle, and a mismatch in any cycle is reported.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam int OPC_W = 4;
  localparam int IMM_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'h0,
    OP_LDI  = 4'h1,
    OP_MOV  = 4'h2,
    OP_ADD  = 4'h3,
    OP_AND  = 4'h4,
    OP_NAND = 4'h5,
    OP_OR   = 4'h6,
    OP_XNOR = 4'h7,
    OP_SHR  = 4'h8,
    OP_SHL  = 4'h9,
    OP_SWP  = 4'hA,
    OP_JMP  = 4'hB,
    OP_JZ   = 4'hC,
    OP_RD   = 4'hD,
    OP_WR   = 4'hE,
    OP_HLT  = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    ST_F0   = 3'd0,
    ST_F1   = 3'd1,
    ST_F2   = 3'd2,
    ST_X1   = 3'd3,
    ST_X2   = 3'd4,
    ST_X3   = 3'd5,
    ST_HALT = 3'd6
  } state_e;

  // two-operand operations that read Rx and the staged source
  function automatic logic is_alu2(op_e op);
    return op inside {OP_ADD, OP_AND, OP_NAND, OP_OR, OP_XNOR};
  endfunction

  function automatic logic needs_x2(op_e op);
    return is_alu2(op) || op inside {OP_SWP, OP_RD, OP_WR};
  endfunction

endpackage

// File: rtl/cpu8_seq.sv
module cpu8_seq
  import cpu8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  op_e    op,
  output state_e state
);

  state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_F0: nxt = ST_F1;
      ST_F1: nxt = ST_F2;
      ST_F2: nxt = ST_X1;
      ST_X1: begin
        if (op == OP_HLT)      nxt = ST_HALT;
        else if (needs_x2(op)) nxt = ST_X2;
        else                   nxt = ST_F0;
      end
      ST_X2:   nxt = (op == OP_SWP || op == OP_RD) ? ST_X3 : ST_F0;
      ST_X3:   nxt = ST_F0;
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_F0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_F0;
    else        state <= nxt;
  end

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  parameter int SW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rx_sel,
  input  logic [SW-1:0] ry_sel,
  output logic [DW-1:0] rx_data,
  output logic [DW-1:0] ry_data,
  output logic [DW-1:0] r0_data
);

  logic [DW-1:0] rq [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && waddr == SW'(g))      q <= wdata;
    end
    assign rq[g] = q;
  end

  assign rx_data = rq[rx_sel];
  assign ry_data = rq[ry_sel];
  assign r0_data = rq[0];

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          ovf
);

  logic [DW:0] sum;

  always_comb begin
    sum = {a[DW-1], a} + {b[DW-1], b};
    ovf = 1'b0;
    y   = b;
    case (op)
      OP_ADD: begin
        y   = sum[DW-1:0];
        ovf = sum[DW] ^ sum[DW-1];
      end
      OP_AND:  y = a & b;
      OP_NAND: y = ~(a & b);
      OP_OR:   y = a | b;
      OP_XNOR: y = ~(a ^ b);
      OP_SHR:  y = {b[DW-1], b[DW-1:1]};
      OP_SHL:  y = {b[DW-2:0], 1'b0};
      default: y = b;
    endcase
  end

  // signed overflow of a sum is only possible with equal operand signs
  always_comb begin
    if (op == OP_ADD && ovf)
      assert_add_sign_R6: assert (a[DW-1] == b[DW-1]);
  end

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              overflow
);

  localparam int IW       = 2 * DATA_W;
  localparam int RSW      = $clog2(NREG);
  localparam int FIELD_HI = IW - OPC_W - 1;

  state_e            state;
  logic [ADDR_W-1:0] pc_q, mar_q, pc_inc, tgt;
  logic [IW-1:0]     ir_q;
  logic [DATA_W-1:0] a_q;
  logic              ovf_q;
  op_e               op;
  logic [RSW-1:0]    rx_sel, ry_sel;
  logic [DATA_W-1:0] imm_ext;

  logic              rf_we;
  logic [RSW-1:0]    rf_waddr;
  logic [DATA_W-1:0] rf_wdata, rx_data, ry_data, r0_data;
  logic [DATA_W-1:0] alu_b, alu_y;
  logic              alu_ovf;
  logic              r0_zero;

  assign op      = op_e'(ir_q[IW-1 -: OPC_W]);
  assign rx_sel  = ir_q[FIELD_HI -: RSW];
  assign ry_sel  = ir_q[FIELD_HI-RSW -: RSW];
  assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, ir_q[FIELD_HI -: IMM_W]};
  assign tgt     = ir_q[ADDR_W-1:0];
  assign pc_inc  = pc_q + ADDR_W'(1);
  assign r0_zero = (r0_data == '0);

  cpu8_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .state (state)
  );

  cpu8_regfile #(.DW(DATA_W), .NREG(NREG), .SW(RSW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .rx_sel  (rx_sel),
    .ry_sel  (ry_sel),
    .rx_data (rx_data),
    .ry_data (ry_data),
    .r0_data (r0_data)
  );

  cpu8_alu #(.DW(DATA_W)) u_alu (
    .op  (op),
    .a   (rx_data),
    .b   (alu_b),
    .y   (alu_y),
    .ovf (alu_ovf)
  );

  // register write-back selection per state
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = rx_sel;
    rf_wdata = alu_y;
    alu_b    = (state == ST_X1) ? ry_data : a_q;
    case (state)
      ST_X1: begin
        case (op)
          OP_LDI: begin
            rf_we    = 1'b1;
            rf_waddr = '0;
            rf_wdata = imm_ext;
          end
          OP_MOV: begin
            rf_we    = 1'b1;
            rf_wdata = ry_data;
          end
          OP_SHR, OP_SHL: rf_we = 1'b1;
          default: ;
        endcase
      end
      ST_X2: begin
        if (is_alu2(op)) begin
          rf_we = 1'b1;
        end else if (op == OP_SWP) begin
          rf_we    = 1'b1;
          rf_waddr = ry_sel;
          rf_wdata = rx_data;
        end
      end
      ST_X3: begin
        if (op == OP_SWP) begin
          rf_we    = 1'b1;
          rf_wdata = a_q;
        end else if (op == OP_RD) begin
          rf_we    = 1'b1;
          rf_waddr = '0;
          rf_wdata = mem_rdata;
        end
      end
      default: ;
    endcase
  end

  // program counter, address register, instruction and staging registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      ovf_q <= 1'b0;
    end else begin
      case (state)
        ST_F0: begin
          pc_q  <= pc_inc;
          mar_q <= pc_inc;
        end
        ST_F1: begin
          ir_q[IW-1:DATA_W] <= mem_rdata;
          pc_q  <= pc_inc;
          mar_q <= pc_inc;
        end
        ST_F2: ir_q[DATA_W-1:0] <= mem_rdata;
        ST_X1: begin
          if (is_alu2(op) || op == OP_SWP) a_q <= ry_data;
          if (op == OP_JMP || (op == OP_JZ && r0_zero)) begin
            pc_q  <= tgt;
            mar_q <= tgt;
          end
          if (op == OP_RD || op == OP_WR) mar_q <= tgt;
        end
        ST_X2: begin
          if (op == OP_ADD) ovf_q <= alu_ovf;
          if (op == OP_RD || op == OP_WR) mar_q <= pc_q;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_we    = (state == ST_X2) && (op == OP_WR);
  assign mem_wdata = mem_we ? r0_data : '0;
  assign overflow  = ovf_q;

  // every fetch starts from the program counter
  assert_mar_tracks_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F0) |-> (mar_q == pc_q));

  // a halted core keeps the bus frozen and never writes
  assert_halt_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> ($stable(mem_addr) && !mem_we));

  // an unconditional jump redirects the very next bus address
  assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_X1 && op == OP_JMP) |=> (mem_addr == $past(tgt)));

  // overflow changes only after the write-back of an add
  assert_ovf_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(overflow) |-> ($past(state) == ST_X2 && $past(op) == OP_ADD));

  // a write strobe lasts a single cycle
  assert_write_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

endmodule

// File: tb/cpu8_core_test.sv
`timescale 1ns/1ps
module cpu8_core_test;

  localparam int AW  = 12;
  localparam int DW  = 8;
  localparam int MSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          overflow;

  always #2.5 clk = ~clk;

  cpu8_core #(.DATA_W(DW), .ADDR_W(AW), .NREG(4)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .overflow  (overflow)
  );

  logic [7:0] mem [MSZ];  // memory seen by the core
  logic [7:0] mm  [MSZ];  // program image, then the model's memory

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < MSZ; i++) mem[i] <= mm[i];
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int ap = 0;

  int    q_addr[$];
  int    q_we[$];
  int    q_wd[$];
  int    q_ov[$];
  string q_tag[$];

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic put(int hi, int lo);
    mm[ap]     = 8'(hi);
    mm[ap + 1] = 8'(lo);
    ap += 2;
  endtask
  task automatic asm_r(int op, int x, int y); put((op << 4) | (x << 2) | y, 0); endtask
  task automatic asm_i(int v);                put((1 << 4) | v, 0);             endtask
  task automatic asm_a(int op, int a);        put((op << 4) | ((a >> 8) & 15), a & 255); endtask

  function automatic string tag_of(int op);
    case (op)
      1:          return "R3";
      2:          return "R4";
      3:          return "R6";
      4, 5, 6, 7: return "R5";
      8, 9:       return "R7";
      10:         return "R8";
      11, 12:     return "R9";
      13:         return "R10";
      14:         return "R11";
      default:    return "R12";
    endcase
  endfunction

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic push(int a, int w, int d, int o, string t);
    q_addr.push_back(a % MSZ);
    q_we.push_back(w);
    q_wd.push_back(d);
    q_ov.push_back(o);
    q_tag.push_back(t);
  endtask

  // instruction-level model that emits the expected bus per cycle
  task automatic run_model();
    int pc = 0, ov = 0, hi, lo, op, rx, ry, ad, npc, s, tmp;
    int r[4];
    bit halted = 0;
    string t;
    for (int i = 0; i < 4; i++) r[i] = 0;
    for (int n = 0; n < 400 && !halted; n++) begin
      hi  = int'(mm[pc]);
      lo  = int'(mm[(pc + 1) % MSZ]);
      op  = hi >> 4;
      rx  = (hi >> 2) & 3;
      ry  = hi & 3;
      ad  = ((hi & 15) << 8) | lo;
      npc = (pc + 2) % MSZ;
      t   = tag_of(op);
      push(pc, 0, 0, ov, "R2");
      push(pc + 1, 0, 0, ov, "R2");
      push(npc, 0, 0, ov, "R2");
      push(npc, 0, 0, ov, t);
      case (op)
        1: r[0] = hi & 15;
        2: r[rx] = r[ry];
        3: begin
          push(npc, 0, 0, ov, t);
          s = sx(r[rx]) + sx(r[ry]);
          ov = (s > 127 || s < -128) ? 1 : 0;
          r[rx] = s & 255;
        end
        4, 5, 6, 7: begin
          push(npc, 0, 0, ov, t);
          case (op)
            4:       r[rx] = r[rx] & r[ry];
            5:       r[rx] = (~(r[rx] & r[ry])) & 255;
            6:       r[rx] = r[rx] | r[ry];
            default: r[rx] = (~(r[rx] ^ r[ry])) & 255;
          endcase
        end
        8: r[rx] = (r[ry] >> 1) | (r[ry] & 128);
        9: r[rx] = (r[ry] << 1) & 255;
        10: begin
          push(npc, 0, 0, ov, t);
          push(npc, 0, 0, ov, t);
          tmp = r[ry]; r[ry] = r[rx]; r[rx] = tmp;
        end
        11: npc = ad;
        12: if (r[0] == 0) npc = ad;
        13: begin
          push(ad, 0, 0, ov, t);
          push(npc, 0, 0, ov, t);
          r[0] = int'(mm[ad]);
        end
        14: begin
          push(ad, 1, r[0], ov, t);
          mm[ad] = 8'(r[0]);
        end
        15: begin
          for (int k = 0; k < 20; k++) push(npc, 0, 0, ov, t);
          halted = 1;
        end
        default: ;
      endcase
      pc = npc;
    end
  endtask

  task automatic assemble();
    for (int i = 0; i < MSZ; i++) mm[i] = 8'h00;
    asm_i(9);               // R0 = 9
    asm_r(2, 1, 0);         // R1 = R0
    asm_i(7);
    asm_r(3, 1, 0);         // 9 + 7
    asm_r(9, 2, 1);         // shift left
    asm_r(9, 2, 2);
    asm_r(3, 2, 2);         // 64 + 64 overflows
    asm_r(8, 3, 2);         // 0x80 >>> 1 = 0xC0
    asm_r(2, 0, 3);
    asm_a(14, 'h800);
    asm_r(3, 3, 3);         // -64 + -64 = -128, no overflow
    asm_r(4, 3, 1);
    asm_i(5);
    asm_r(6, 3, 0);
    asm_r(5, 1, 3);
    asm_r(7, 2, 1);
    asm_r(3, 1, 1);
    asm_r(10, 1, 3);        // exchange
    asm_r(10, 2, 2);        // exchange with itself
    asm_r(8, 0, 1);
    asm_a(14, 'h801);
    asm_r(2, 0, 1);
    asm_a(14, 'h802);
    asm_r(2, 0, 2);
    asm_a(14, 'h803);
    asm_r(2, 0, 3);
    asm_a(14, 'h804);
    asm_a(13, 'h800);       // read back what was written
    asm_a(12, 'h700);       // not taken, R0 nonzero
    asm_i(0);
    asm_a(12, ap + 6);      // taken, skips two instructions
    asm_i(15);
    asm_a(14, 'h810);
    asm_a(11, ap + 6);      // jump over two instructions
    asm_i(14);
    asm_a(14, 'h811);
    asm_r(0, 0, 0);         // idle
    asm_a(13, 'h800);
    asm_a(14, 'h812);
    asm_r(15, 0, 0);        // stop
  endtask

  initial begin
    int ea, ew, ed, eo, cyc;
    string tg;
    assemble();
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    run_model();
    repeat (2) @(negedge clk);
    #1;
    check("R1", mem_addr == '0 && !mem_we && mem_wdata == '0 && !overflow,
          {mem_addr, mem_we, mem_wdata, overflow}, 0);
    @(negedge clk) rst_n = 1'b1;
    cyc = 0;
    while (q_addr.size() > 0) begin
      #1;
      ea = q_addr.pop_front();
      ew = q_we.pop_front();
      ed = q_wd.pop_front();
      eo = q_ov.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (mem_addr !== AW'(ea) || mem_we !== ew[0] ||
          mem_wdata !== DW'(ed) || overflow !== eo[0]) begin
        errors++;
        $display("FAIL %s cycle %0d: actual addr=%h we=%b wd=%h ovf=%b expected addr=%h we=%0d wd=%h ovf=%0d",
                 tg, cyc, mem_addr, mem_we, mem_wdata, overflow, ea, ew, ed, eo);
      end
      cyc++;
      @(negedge clk);
    end
    check("R7",  mem['h800] == 8'hC0, int'(mem['h800]), 'hC0);
    check("R7",  mem['h801] == 8'h02, int'(mem['h801]), 'h02);
    check("R8",  mem['h802] == 8'h05, int'(mem['h802]), 'h05);
    check("R5",  mem['h803] == 8'h80, int'(mem['h803]), 'h80);
    check("R6",  mem['h804] == 8'hFE, int'(mem['h804]), 'hFE);
    check("R9",  mem['h810] == 8'h00, int'(mem['h810]), 0);
    check("R9",  mem['h811] == 8'h00, int'(mem['h811]), 0);
    check("R10", mem['h812] == 8'hC0, int'(mem['h812]), 'hC0);
    check("R6",  overflow == 1'b0, int'(overflow), 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule